// File: doc/BRIEF.md
# Host Firmware-Cycle Address Remap Window

This block sits between the slave front end of a low-pin-count host link and the local bus master. Each host firmware or memory cycle carries a 32-bit address. The block decides whether that address falls inside a single remap window. If it does, the block produces the matching local bus address. If it does not, or if the window is switched off, the block signals an error and issues no local request.

The window works on 64 KiB pages. Host address bits 15:0 always reach the local bus unchanged. The upper 16 bits are rebuilt by a bitwise merge under two 16-bit masks. A "keep" mask picks the host bits that pass through. A "replace" mask picks the bits that come from a programmed local base. Because the two parts are merged with OR and not added, the local base must be aligned to the window size. If it is not, the reachable local space breaks into fragments.

A local processor programs the window through three 32-bit registers on a small register port:
- a control word at byte offset 0x0,
- a base word at 0x8,
- a mask word at 0xC.

Top module: `fwh_remap_window`

## Requirements
- R1: After a synchronous reset, all three registers read as zero. Both `loc_req_valid` and `host_err` are low, so the window is disabled.
- R2: A write with `reg_wr_en` high stores `reg_wdata` at offset 0x0 (control), 0x8 (base) or 0xC (mask). `reg_rdata` returns, combinationally, the last value written at the offset on `reg_ofs`. Any other offset reads as zero, and a write to it changes none of the three registers.
- R3: The window accepts requests only when control bit 10 (firmware cycle enable) and control bit 8 (host-to-local forwarding enable) are both 1. A request at any other time gets an error.
- R4: A request hits the window when host bits 31:16, masked by the inverse of the keep mask (mask bits 15:0), equal base bits 15:0 masked in the same way. A miss gets an error.
- R5: For a hit, local address bits 31:16 equal (host[31:16] AND mask[15:0]) OR (base[31:16] AND mask[31:16]).
- R6: For a hit, local address bits 15:0 equal host address bits 15:0.
- R7: A request sampled on a clock edge gives its result right after that edge, and the result lasts exactly one cycle. The result is either `loc_req_valid` high with the address, or a one-cycle `host_err` pulse with `loc_req_valid` low. With no request, both outputs are low. The two outputs are never high together.
- R8: A request presented in the same cycle as a register write uses the old register values. The next request uses the new values.
- R9: Where a replace-mask bit and a keep-mask bit overlap, the local bit is the OR of the host bit and the base bit. For example, with mask 0xFFFF0001 and local base upper half 0x2341, host pages 0x00FE and 0x00FF both map to local page 0x2341.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_ofs | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_ofs` |
| host_req_valid | input | 1 | Host cycle request strobe |
| host_req_addr | input | 32 | Host cycle address |
| loc_req_valid | output | 1 | Translated local request strobe |
| loc_req_addr | output | 32 | Translated local address |
| host_err | output | 1 | One-cycle error / no-response pulse |

## Verification
A wrong stored mask or base shows up at the ports on the first request after the write. It appears as a wrong upper address half, or as a hit and miss that are swapped. The error pulse or the missing valid strobe marks that request one cycle after it was presented. A stuck enable bit turns every later request into an error, or lets requests through that should fail, so the first request after the change exposes it. Register corruption that no request happens to touch is caught by read-back, which shows each register combinationally.

// File: rtl/fwr_pkg.sv
package fwr_pkg;
    localparam int ADDR_W = 32;
    localparam int PAGE_W = 16;
    localparam int HI_W   = ADDR_W - PAGE_W;
    localparam int OFS_W  = 4;

    localparam logic [OFS_W-1:0] CTRL_OFS = 4'h0;
    localparam logic [OFS_W-1:0] BASE_OFS = 4'h8;
    localparam logic [OFS_W-1:0] MASK_OFS = 4'hC;

    localparam int FWH_EN_BIT = 10;
    localparam int FWD_EN_BIT = 8;

    typedef struct packed {
        logic [HI_W-1:0] loc_hi;   // local target upper bits
        logic [HI_W-1:0] host_hi;  // host match upper bits
    } base_t;

    typedef struct packed {
        logic [HI_W-1:0] replace;  // 1 = take bit from base
        logic [HI_W-1:0] keep;     // 1 = take bit from host
    } mask_t;

    typedef struct packed {
        logic            fire;     // translated request
        logic            err;      // rejected request
        logic [ADDR_W-1:0] addr;
    } resp_t;

    function automatic logic is_mapped(input logic [OFS_W-1:0] ofs);
        return (ofs == CTRL_OFS) || (ofs == BASE_OFS) || (ofs == MASK_OFS);
    endfunction
endpackage

// File: rtl/fwr_regs.sv
module fwr_regs
    import fwr_pkg::*;
#(
    parameter int DW = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] ofs,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             win_en,
    output base_t            base_q,
    output mask_t            mask_q
);
    logic [DW-1:0] ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            base_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            case (ofs)
                CTRL_OFS: ctrl_q <= wdata;
                BASE_OFS: base_q <= wdata;
                MASK_OFS: mask_q <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (ofs)
            CTRL_OFS: rdata = ctrl_q;
            BASE_OFS: rdata = base_q;
            MASK_OFS: rdata = mask_q;
            default:  rdata = '0;
        endcase
    end

    assign win_en = ctrl_q[FWH_EN_BIT] & ctrl_q[FWD_EN_BIT];

    // R2: a mapped write lands in the addressed register on the next edge
    a_r2_base_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ofs == BASE_OFS) |=> (base_q == $past(wdata)));
    a_r2_mask_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ofs == MASK_OFS) |=> (mask_q == $past(wdata)));
    // R2: unmapped writes leave the window registers untouched
    a_r2_unmapped_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !is_mapped(ofs)) |=> ($stable(base_q) && $stable(mask_q) && $stable(ctrl_q)));
endmodule

// File: rtl/fwr_match.sv
module fwr_match #(
    parameter int HI_W = 16
) (
    input  logic [HI_W-1:0] host_hi,
    input  logic [HI_W-1:0] win_hi,
    input  logic [HI_W-1:0] keep,
    output logic            hit
);
    logic [HI_W-1:0] cmp_mask;
    assign cmp_mask = ~keep;
    assign hit = ((host_hi & cmp_mask) == (win_hi & cmp_mask));
endmodule

// File: rtl/fwr_merge.sv
module fwr_merge #(
    parameter int HI_W = 16
) (
    input  logic [HI_W-1:0] host_hi,
    input  logic [HI_W-1:0] base_hi,
    input  logic [HI_W-1:0] keep,
    input  logic [HI_W-1:0] replace,
    output logic [HI_W-1:0] loc_hi
);
    for (genvar i = 0; i < HI_W; i++) begin : g_bit
        assign loc_hi[i] = (host_hi[i] & keep[i]) | (base_hi[i] & replace[i]);
    end
endmodule

// File: rtl/fwh_remap_window.sv
module fwh_remap_window
    import fwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [OFS_W-1:0]  reg_ofs,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              host_req_valid,
    input  logic [ADDR_W-1:0] host_req_addr,
    output logic              loc_req_valid,
    output logic [ADDR_W-1:0] loc_req_addr,
    output logic              host_err
);
    logic      win_en;
    base_t     base_q;
    mask_t     mask_q;
    logic      hit;
    logic [HI_W-1:0] merged_hi;
    resp_t     resp_d, resp_q;

    fwr_regs #(.DW(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr_en),
        .ofs    (reg_ofs),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .win_en (win_en),
        .base_q (base_q),
        .mask_q (mask_q)
    );

    fwr_match #(.HI_W(HI_W)) u_match (
        .host_hi (host_req_addr[ADDR_W-1:PAGE_W]),
        .win_hi  (base_q.host_hi),
        .keep    (mask_q.keep),
        .hit     (hit)
    );

    fwr_merge #(.HI_W(HI_W)) u_merge (
        .host_hi (host_req_addr[ADDR_W-1:PAGE_W]),
        .base_hi (base_q.loc_hi),
        .keep    (mask_q.keep),
        .replace (mask_q.replace),
        .loc_hi  (merged_hi)
    );

    always_comb begin
        resp_d      = resp_q;
        resp_d.fire = 1'b0;
        resp_d.err  = 1'b0;
        if (host_req_valid) begin
            if (win_en && hit) begin
                resp_d.fire = 1'b1;
                resp_d.addr = {merged_hi, host_req_addr[PAGE_W-1:0]};
            end else begin
                resp_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) resp_q <= '0;
        else     resp_q <= resp_d;
    end

    assign loc_req_valid = resp_q.fire;
    assign host_err      = resp_q.err;
    assign loc_req_addr  = resp_q.addr;

    // R1: reset clears both response outputs
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!loc_req_valid && !host_err));
    // R7: outputs are mutually exclusive
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(loc_req_valid && host_err));
    // R7: no request, no response
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !host_req_valid |=> (!loc_req_valid && !host_err));
    // R7: every request gets exactly one kind of response
    a_r7_one_resp: assert property (@(posedge clk) disable iff (rst)
        host_req_valid |=> $onehot({loc_req_valid, host_err}));
    // R3: a disabled window rejects
    a_r3_disabled_err: assert property (@(posedge clk) disable iff (rst)
        (host_req_valid && !win_en) |=> host_err);
    // R6: low page bits pass straight through
    a_r6_low_pass: assert property (@(posedge clk) disable iff (rst)
        host_req_valid |=> (!loc_req_valid ||
            loc_req_addr[PAGE_W-1:0] == $past(host_req_addr[PAGE_W-1:0])));
endmodule

// File: tb/fwh_remap_window_tb_top.sv
module fwh_remap_window_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr_en;
    logic [3:0]  reg_ofs;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        host_req_valid;
    logic [31:0] host_req_addr;
    logic        loc_req_valid;
    logic [31:0] loc_req_addr;
    logic        host_err;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] sh_ctrl, sh_base, sh_mask;

    always #4 clk = ~clk;

    fwh_remap_window dut_i (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_ofs(reg_ofs), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .host_req_valid(host_req_valid), .host_req_addr(host_req_addr),
        .loc_req_valid(loc_req_valid), .loc_req_addr(loc_req_addr), .host_err(host_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // returns {valid, err, addr}
    function automatic logic [33:0] model(input logic [31:0] a);
        logic [15:0] keep, rep, hi;
        logic en, hit;
        keep = sh_mask[15:0];
        rep  = sh_mask[31:16];
        en   = sh_ctrl[10] & sh_ctrl[8];
        hit  = ((a[31:16] & ~keep) == (sh_base[15:0] & ~keep));
        hi   = (a[31:16] & keep) | (sh_base[31:16] & rep);
        if (en && hit) return {1'b1, 1'b0, hi, a[15:0]};
        return {1'b0, 1'b1, 32'h0};
    endfunction

    task automatic shadow(input logic [3:0] ofs, input logic [31:0] d);
        case (ofs)
            4'h0: sh_ctrl = d;
            4'h8: sh_base = d;
            4'hC: sh_mask = d;
            default: ;
        endcase
    endtask

    task automatic wr(input logic [3:0] ofs, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1; reg_ofs = ofs; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 0;
        shadow(ofs, d);
    endtask

    task automatic rd_chk(input logic [3:0] ofs, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_ofs = ofs;
        #1;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic resp_chk(input logic [33:0] e, input string tag);
        chk(loc_req_valid == e[33], {tag, " valid"}, 32'(loc_req_valid), 32'(e[33]));
        chk(host_err == e[32], {tag, " err"}, 32'(host_err), 32'(e[32]));
        if (e[33]) chk(loc_req_addr == e[31:0], {tag, " addr"}, loc_req_addr, e[31:0]);
    endtask

    task automatic req(input logic [31:0] a, input string tag);
        logic [33:0] e;
        @(negedge clk);
        host_req_valid = 1; host_req_addr = a;
        e = model(a);
        @(negedge clk);
        host_req_valid = 0;
        resp_chk(e, tag);
    endtask

    task automatic req_lit(input logic [31:0] a, input logic [31:0] exp_addr, input string tag);
        @(negedge clk);
        host_req_valid = 1; host_req_addr = a;
        @(negedge clk);
        host_req_valid = 0;
        chk(loc_req_valid && !host_err, {tag, " hit"}, 32'(loc_req_valid), 32'h1);
        chk(loc_req_addr == exp_addr, {tag, " addr"}, loc_req_addr, exp_addr);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [33:0] e;
        int unsigned seed;
        sh_ctrl = 0; sh_base = 0; sh_mask = 0;
        rst = 1; reg_wr_en = 0; reg_ofs = 0; reg_wdata = 0;
        host_req_valid = 0; host_req_addr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(!loc_req_valid && !host_err, "R1 outputs after reset", {30'h0, loc_req_valid, host_err}, 32'h0);
        rd_chk(4'h0, 32'h0, "R1 ctrl reset");
        rd_chk(4'h8, 32'h0, "R1 base reset");
        rd_chk(4'hC, 32'h0, "R1 mask reset");
        req(32'h0000_0000, "R1 disabled after reset");

        // R2 register map and readback
        wr(4'h8, 32'h2340_00FE);
        wr(4'hC, 32'hFFFE_0001);
        wr(4'h0, 32'h0000_0500);
        rd_chk(4'h0, 32'h0000_0500, "R2 ctrl readback");
        rd_chk(4'h8, 32'h2340_00FE, "R2 base readback");
        rd_chk(4'hC, 32'hFFFE_0001, "R2 mask readback");
        wr(4'h4, 32'hDEAD_BEEF);
        rd_chk(4'h4, 32'h0, "R2 unmapped reads zero");
        rd_chk(4'h8, 32'h2340_00FE, "R2 unmapped write ignored base");
        rd_chk(4'hC, 32'hFFFE_0001, "R2 unmapped write ignored mask");
        rd_chk(4'h0, 32'h0000_0500, "R2 unmapped write ignored ctrl");

        // R4 R5 R6 hits and misses, 128 KiB window
        req_lit(32'h00FE_1234, 32'h2340_1234, "R5 page0");
        req_lit(32'h00FF_ABCD, 32'h2341_ABCD, "R6 page1");
        req(32'h0100_0000, "R4 miss above");
        req(32'h00FC_FFFF, "R4 miss below");
        // R7 idle cycle quiet
        @(negedge clk);
        chk(!loc_req_valid && !host_err, "R7 idle quiet", {30'h0, loc_req_valid, host_err}, 32'h0);
        // R7 back-to-back
        @(negedge clk);
        host_req_valid = 1; host_req_addr = 32'h00FE_0001;
        @(negedge clk);
        resp_chk(model(32'h00FE_0001), "R7 b2b first");
        host_req_addr = 32'h0200_0000;
        @(negedge clk);
        host_req_valid = 0;
        resp_chk(model(32'h0200_0000), "R7 b2b second");
        @(negedge clk);
        chk(!host_err, "R7 err one cycle", 32'(host_err), 32'h0);

        // R3 enable gating
        wr(4'h0, 32'h0000_0400);
        req(32'h00FE_0000, "R3 only fwh bit");
        wr(4'h0, 32'h0000_0100);
        req(32'h00FE_0000, "R3 only fwd bit");
        wr(4'h0, 32'hFFFF_FAFF);
        req(32'h00FE_0000, "R3 both bits clear");
        wr(4'h0, 32'h0000_0500);
        req(32'h00FE_0000, "R3 both set");

        // R8 write and request in the same cycle
        @(negedge clk);
        reg_wr_en = 1; reg_ofs = 4'h0; reg_wdata = 32'h0;
        host_req_valid = 1; host_req_addr = 32'h00FE_0042;
        e = model(32'h00FE_0042);
        @(negedge clk);
        reg_wr_en = 0; host_req_valid = 0;
        resp_chk(e, "R8 same cycle uses old");
        shadow(4'h0, 32'h0);
        req(32'h00FE_0042, "R8 next uses new");
        wr(4'h0, 32'h0000_0500);

        // R9 overlapping masks alias pages
        wr(4'hC, 32'hFFFF_0001);
        wr(4'h8, 32'h2341_00FE);
        req_lit(32'h00FE_0000, 32'h2341_0000, "R9 page0");
        req_lit(32'h00FF_0000, 32'h2341_0000, "R9 page1 alias");

        // random windows
        seed = $urandom(32'h5EED_1234);
        for (int it = 0; it < 400; it++) begin
            if (it % 10 == 0) begin
                int k;
                logic [15:0] keep, hh, lh;
                k = $urandom_range(0, 15);
                keep = 16'((32'h1 << k) - 1);
                hh = 16'($urandom) & ~keep;
                lh = 16'($urandom) & ~keep;
                wr(4'hC, {~keep, keep});
                wr(4'h8, {lh, hh});
                wr(4'h0, ($urandom_range(0, 3) == 0) ? 32'($urandom) : 32'h0000_0500);
            end
            if ($urandom_range(0, 1) == 1)
                req({sh_base[15:0] | (16'($urandom) & sh_mask[15:0]), 16'($urandom)}, "R5 random hit");
            else
                req($urandom, "R4 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule